// File: doc/BRIEF.md
# Banked Scratchpad with Conflict Serialization

This block is a word-addressed scratchpad shared by a group of 16 lanes. The storage is split into 16 banks, each able to serve one access per cycle. A group is presented in one cycle. In that group, every lane may ask for a read or a write of a 32-bit word. Lanes whose words sit in different banks are served in the same cycle. Lanes that land in the same bank are served one after another, with the lowest-numbered lane first.

While a group is being worked off, `stall` is high and new groups are not taken. In the cycle after the last access, `rsp_valid` pulses once. At that point `rsp_mask` marks the lanes that read, and `rsp_rdata` carries their words. Reset returns the control logic to idle and leaves the stored words untouched.

Top module: `bank_spad`

## Requirements
- R1: After reset, `stall` and `rsp_valid` are low and the block is ready to take a group.
- R2: A word address selects bank `addr % 16` (the four low bits) and row `addr / 16` within that bank.
- R3: A group in which no two enabled lanes share a bank holds `stall` for exactly one cycle.
- R4: A group holds `stall` for as many cycles as the largest number of enabled lanes aimed at one bank, and for at least one cycle.
- R5: Lanes that share a bank are served in rising lane order, one per cycle. A read therefore sees writes by lower lanes to the same word. When several lanes write one word, the highest enabled lane's data is what remains stored.
- R6: `rsp_valid` is high for exactly the one cycle after the last stalled cycle. In that cycle, `rsp_mask` bit n is set when lane n was enabled and not writing. `rsp_rdata` lane n (bits 32n+31:32n) holds that lane's word, and it is zero for lanes outside the mask.
- R7: Reads by several lanes of the same word are still served one per cycle, so 16 such reads take 16 stalled cycles.
- R8: `req_valid` and the lane inputs presented while `stall` is high are ignored: no word is written and the running group is unchanged.
- R9: A group with no enabled lane takes one stalled cycle and returns an empty mask.
- R10: Reset does not alter stored words: data written before a reset reads back unchanged after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| req_valid | input | 1 | A group is presented; taken when `stall` is low |
| lane_en | input | 16 | Lane n takes part in the group |
| lane_we | input | 16 | Lane n writes (1) or reads (0) |
| lane_addr | input | 160 | Word address of lane n at bits 10n+9:10n |
| lane_wdata | input | 512 | Write data of lane n at bits 32n+31:32n |
| stall | output | 1 | Group in progress; inputs ignored |
| rsp_valid | output | 1 | One-cycle pulse: group finished |
| rsp_mask | output | 16 | Lanes whose read data is valid |
| rsp_rdata | output | 512 | Read data of lane n at bits 32n+31:32n |

## Verification
The address patterns are unit stride, stride 2, 3, 4, 8, 16 and 17, and stride 0, each with chosen enable and write masks. Together they separate the conflict-free case from two-way, four-way and sixteen-way bank pile-ups. Stride 17 wraps around the banks and must not be mistaken for a conflict. Stride-0 groups tell apart lane-order serialization, last-writer-wins, a read following a lower lane's write, and the missing broadcast. A write group whose inputs are changed during its stall, an empty group, and a reset between a write and its readback check that ignored inputs and reset leave the stored words alone.

// File: rtl/spad_pkg.sv
package spad_pkg;
    localparam int SPAD_LANES = 16;
    localparam int SPAD_BANKS = 16;
    localparam int SPAD_AW    = 10;
    localparam int SPAD_DW    = 32;
endpackage

// File: rtl/spad_pick.sv
// Fixed-priority picker: the lowest requesting index wins.
module spad_pick #(
    parameter int N  = 16,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] idx
);
    always_comb begin
        gnt = '0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt    = '0;
                gnt[i] = 1'b1;
                idx    = IW'(i);
            end
        end
    end
endmodule

// File: rtl/spad_bank.sv
// One bank: a single port, asynchronous read, write at the clock edge, no reset.
module spad_bank #(
    parameter int ROWS = 64,
    parameter int DW   = 32,
    localparam int RW  = $clog2(ROWS)
) (
    input  logic          clk,
    input  logic          wr,
    input  logic [RW-1:0] row,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [ROWS];

    assign rdata = mem[row];

    always_ff @(posedge clk) begin
        if (wr) mem[row] <= wdata;
    end
endmodule

// File: rtl/bank_spad.sv
module bank_spad
    import spad_pkg::*;
#(
    parameter int NL = SPAD_LANES,
    parameter int NB = SPAD_BANKS,
    parameter int AW = SPAD_AW,
    parameter int DW = SPAD_DW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [NL-1:0]    lane_en,
    input  logic [NL-1:0]    lane_we,
    input  logic [NL*AW-1:0] lane_addr,
    input  logic [NL*DW-1:0] lane_wdata,
    output logic             stall,
    output logic             rsp_valid,
    output logic [NL-1:0]    rsp_mask,
    output logic [NL*DW-1:0] rsp_rdata
);
    localparam int BW   = $clog2(NB);
    localparam int RW   = AW - BW;
    localparam int ROWS = 1 << RW;
    localparam int LW   = (NL > 1) ? $clog2(NL) : 1;
    localparam int CW   = $clog2(NL + 1) + 1;

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [NL-1:0] pend;
        logic [NL-1:0] wr;
        logic [NL-1:0] rdm;
    } ctl_t;

    typedef struct packed {
        logic [NL-1:0][AW-1:0] addr;
        logic [NL-1:0][DW-1:0] wdata;
        logic [NL-1:0][DW-1:0] rdata;
    } dp_t;

    ctl_t ctl_d, ctl_q;
    dp_t  dp_d, dp_q;

    logic [BW-1:0] lane_bank [NL];
    logic [RW-1:0] lane_row  [NL];
    logic [NL-1:0] bank_req  [NB];
    logic [NL-1:0] bank_gnt  [NB];
    logic [LW-1:0] bank_idx  [NB];
    logic [DW-1:0] bank_rd   [NB];
    logic [NL-1:0] lane_gnt;
    logic [NL-1:0] pend_left;

    // R2: bank from the low address bits, row from the rest
    always_comb begin
        for (int l = 0; l < NL; l++) begin
            lane_bank[l] = dp_q.addr[l][BW-1:0];
            lane_row[l]  = dp_q.addr[l][AW-1:BW];
        end
    end

    for (genvar b = 0; b < NB; b++) begin : g_bank
        always_comb begin
            for (int l = 0; l < NL; l++)
                bank_req[b][l] = ctl_q.pend[l] && (lane_bank[l] == BW'(b));
        end

        spad_pick #(.N(NL)) i_pick (
            .req (bank_req[b]),
            .gnt (bank_gnt[b]),
            .idx (bank_idx[b])
        );

        spad_bank #(.ROWS(ROWS), .DW(DW)) i_bank (
            .clk   (clk),
            .wr    ((|bank_gnt[b]) && ctl_q.wr[bank_idx[b]]),
            .row   (lane_row[bank_idx[b]]),
            .wdata (dp_q.wdata[bank_idx[b]]),
            .rdata (bank_rd[b])
        );
    end

    always_comb begin
        for (int l = 0; l < NL; l++)
            lane_gnt[l] = bank_gnt[lane_bank[l]][l];
    end

    assign pend_left = ctl_q.pend & ~lane_gnt;

    always_comb begin
        ctl_d      = ctl_q;
        dp_d       = dp_q;
        ctl_d.done = 1'b0;
        if (!ctl_q.busy) begin
            if (req_valid) begin
                ctl_d.busy  = 1'b1;
                ctl_d.pend  = lane_en;
                ctl_d.wr    = lane_we;
                ctl_d.rdm   = lane_en & ~lane_we;
                dp_d.addr   = lane_addr;
                dp_d.wdata  = lane_wdata;
                dp_d.rdata  = '0;
            end
        end else begin
            ctl_d.pend = pend_left;
            for (int l = 0; l < NL; l++) begin
                if (lane_gnt[l] && !ctl_q.wr[l])
                    dp_d.rdata[l] = bank_rd[lane_bank[l]];
            end
            if (pend_left == '0) begin
                ctl_d.busy = 1'b0;
                ctl_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_ff @(posedge clk) begin
        dp_q <= dp_d;
    end

    assign stall     = ctl_q.busy;
    assign rsp_valid = ctl_q.done;
    assign rsp_mask  = ctl_q.done ? ctl_q.rdm : '0;
    assign rsp_rdata = dp_q.rdata;

    // Checker state: length of the current stall run
    logic [CW-1:0] run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     run_q <= '0;
        else if (stall) run_q <= run_q + 1'b1;
        else            run_q <= '0;
    end

    // R4: a group never stalls longer than one cycle per lane
    a_r4_stall_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= CW'(NL));

    // R5: every busy cycle with work left serves at least one lane
    a_r5_progress: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.busy && ctl_q.pend != '0) |=>
            ($countones(ctl_q.pend) < $countones($past(ctl_q.pend))));

    // R6: the response follows a stall and never overlaps one
    a_r6_rsp_after_stall: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(stall) && !stall));

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R8: addresses held steady for the whole group
    a_r8_inputs_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && $past(stall)) |-> $stable(dp_q.addr));
endmodule

// File: tb/test_bank_spad.sv
`timescale 1ns/1ps
module test_bank_spad;
    localparam int NL = 16;
    localparam int AW = 10;
    localparam int DW = 32;
    localparam int WORDS = 1 << AW;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [NL-1:0]    lane_en = '0;
    logic [NL-1:0]    lane_we = '0;
    logic [NL*AW-1:0] lane_addr = '0;
    logic [NL*DW-1:0] lane_wdata = '0;
    logic             stall;
    logic             rsp_valid;
    logic [NL-1:0]    rsp_mask;
    logic [NL*DW-1:0] rsp_rdata;

    always #5 clk = ~clk;

    bank_spad i_bank_spad (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .lane_en(lane_en), .lane_we(lane_we), .lane_addr(lane_addr),
        .lane_wdata(lane_wdata), .stall(stall), .rsp_valid(rsp_valid),
        .rsp_mask(rsp_mask), .rsp_rdata(rsp_rdata)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int tag      = 0;
    logic [DW-1:0] model [WORDS];

    // en, we, base, stride, expected stall cycles
    localparam int NV = 13;
    localparam logic [71:0] TAB [NV] = '{
        {16'hFFFF, 16'h0000, 16'd0,   16'd1,  8'd1},
        {16'hFFFF, 16'hFFFF, 16'd5,   16'd2,  8'd2},
        {16'hFFFF, 16'h0000, 16'd5,   16'd2,  8'd2},
        {16'hFFFF, 16'hFFFF, 16'd100, 16'd16, 8'd16},
        {16'hFFFF, 16'h00FF, 16'd3,   16'd17, 8'd1},
        {16'hFFFF, 16'hFFFF, 16'd40,  16'd0,  8'd16},
        {16'hFFFF, 16'h0000, 16'd40,  16'd0,  8'd16},
        {16'h0F0F, 16'h0505, 16'd200, 16'd8,  8'd4},
        {16'hAAAA, 16'h0000, 16'd7,   16'd4,  8'd4},
        {16'hFFFF, 16'hFFFF, 16'd300, 16'd3,  8'd1},
        {16'hFFFF, 16'h0000, 16'd300, 16'd3,  8'd1},
        {16'hFFFF, 16'h3333, 16'd64,  16'd1,  8'd1},
        {16'hFFFF, 16'h0001, 16'd500, 16'd0,  8'd16}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input logic [NL*DW-1:0] act, input logic [NL*DW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Runs one group; junk=1 drives different write traffic during the stall.
    task automatic run_group(input logic [NL-1:0] en, input logic [NL-1:0] we,
                             input int base, input int stride, input int exp_cyc,
                             input bit junk, input string req);
        logic [NL*AW-1:0] a;
        logic [NL*DW-1:0] wd;
        logic [NL*DW-1:0] exp_rd;
        logic [NL-1:0]    exp_mask;
        int cnt;
        tag++;
        exp_rd = '0;
        for (int l = 0; l < NL; l++) begin
            int ad;
            ad = (base + stride * l) % WORDS;
            a[l*AW +: AW]  = AW'(ad);
            wd[l*DW +: DW] = 32'hA500_0000 ^ (tag << 16) ^ (l << 10) ^ ad;
        end
        // lane-order reference model
        for (int l = 0; l < NL; l++) begin
            if (en[l]) begin
                if (we[l]) model[a[l*AW +: AW]] = wd[l*DW +: DW];
                else       exp_rd[l*DW +: DW] = model[a[l*AW +: AW]];
            end
        end
        exp_mask = en & ~we;
        @(negedge clk);
        req_valid  = 1'b1;
        lane_en    = en;
        lane_we    = we;
        lane_addr  = a;
        lane_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        if (junk) begin
            lane_en = '1;
            lane_we = '1;
            for (int l = 0; l < NL; l++) begin
                lane_addr[l*AW +: AW]  = AW'(900 + l);
                lane_wdata[l*DW +: DW] = 32'hDEAD_0000 + l;
            end
        end else begin
            req_valid = 1'b0;
        end
        cnt = 0;
        while (stall && cnt < 64) begin
            cnt++;
            @(negedge clk);
        end
        req_valid = 1'b0;
        check(cnt == exp_cyc, exp_cyc == 1 ? "R3/R4" : "R4", "stall cycles",
              (NL*DW)'(cnt), (NL*DW)'(exp_cyc));
        check(rsp_valid === 1'b1, "R6", "rsp_valid after stall",
              (NL*DW)'(rsp_valid), (NL*DW)'(1));
        check(rsp_mask === exp_mask, "R6", "rsp_mask",
              (NL*DW)'(rsp_mask), (NL*DW)'(exp_mask));
        check(rsp_rdata === exp_rd, req, "read data", rsp_rdata, exp_rd);
        @(negedge clk);
        check(rsp_valid === 1'b0, "R6", "single response pulse",
              (NL*DW)'(rsp_valid), '0);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle after reset
        check(stall === 1'b0 && rsp_valid === 1'b0, "R1", "idle after reset",
              (NL*DW)'({stall, rsp_valid}), '0);

        // prefill every word, conflict-free (R3)
        for (int g = 0; g < WORDS / NL; g++)
            run_group('1, '1, g * NL, 1, 1, 1'b0, "R3");

        // R2/R4/R5/R6/R7 table walk
        for (int v = 0; v < NV; v++) begin
            string rq;
            rq = (TAB[v][23:8] == 16'd0) ? "R5/R7" : "R2/R5";
            run_group(TAB[v][71:56], TAB[v][55:40], int'(TAB[v][39:24]),
                      int'(TAB[v][23:8]), int'(TAB[v][7:0]), 1'b0, rq);
        end

        // R8: a 16-way conflicting write with changed inputs during the stall
        run_group('1, '1, 600, 16, 16, 1'b1, "R8");
        run_group('1, '0, 896, 1, 1, 1'b0, "R8");

        // R9: empty group
        run_group('0, '0, 0, 1, 1, 1'b0, "R9");

        // R10: stored words survive a reset
        run_group('1, '1, 16, 1, 1, 1'b0, "R10");
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(stall === 1'b0 && rsp_valid === 1'b0, "R1", "idle after second reset",
              (NL*DW)'({stall, rsp_valid}), '0);
        run_group('1, '0, 16, 1, 1, 1'b0, "R10");

        finish_run();
    end
endmodule